// File: doc/BRIEF.md
# Host-Bus Link Adapter Register Window

This block sits between an 8-bit host bus and a byte-wide serial-link core that serves an attached processor. The host sees a 16-byte window of registers. Six offsets in that window are live: one takes the byte the link has received, one hands a byte to the link for sending, two report and control the receive and transmit directions, one drives the processor reset line and reads back its error flag, and one drives the processor analyse line. The window base is either a fixed parameter or is computed from a slot number, as `SLOT_BASE + 16 * slot`.

On the link side each direction uses a valid/ready handshake. The receive direction is a two-state machine. `RX_EMPTY` holds `lk_rx_ready` high, and a handshake moves it to `RX_FULL` (transition *capture*). A host read of the data register moves it back to `RX_EMPTY` (transition *consume*). The transmit direction is also a two-state machine. A host write while in `TX_IDLE` captures the byte and moves to `TX_SEND` (transition *load*). `TX_SEND` presents the byte with `lk_tx_valid` and returns to `TX_IDLE` on `lk_tx_ready` (transition *drain*). Each direction also has an interrupt enable and a sticky error bit: underrun for receive and overrun for transmit. Their enabled ready conditions are ORed into one interrupt output.

Host reads are combinational: `host_rdata` shows the addressed register while `host_rd` is high. All register side effects, and the reset line, take effect on the rising clock edge that ends the access.

Top module: `hl_regif`

## Requirements
- R1: The window covers 16 bytes at a base address. With SLOT_MODE=0 the base is FIXED_BASE (default 0xDE00). With SLOT_MODE=1 the base is SLOT_BASE (0xC080) + 16*slot. Accesses outside the window read 0x00 and change nothing.
- R2: Only offsets 0x0, 0x1, 0x2, 0x3, 0x8 and 0xC are decoded. Reads of any other offset return 0x00, and writes to them have no effect.
- R3: Writing offset 0x8 sets cpu_reset to data bit 0 at the end of the write. Reading offset 0x8 returns cpu_error in bit 0, with bits 7..1 zero.
- R4: Writing offset 0xC sets cpu_analyse to data bit 0. Reading offset 0xC returns cpu_analyse in bit 0.
- R5: In RX_EMPTY, lk_rx_ready is high and a byte offered with lk_rx_valid is captured. In RX_FULL, lk_rx_ready is low and the held byte does not change. Input status (offset 0x2) bit 0 is 1 exactly in RX_FULL.
- R6: Reading offset 0x0 in RX_FULL returns the held byte. After that access, status bit 0 reads 0 and lk_rx_ready is high.
- R7: Reading offset 0x0 in RX_EMPTY returns the last captured byte and sets the sticky underrun bit, which is bit 2 of offset 0x2.
- R8: Writing offset 0x1 in TX_IDLE raises lk_tx_valid with that byte on lk_tx_data from the next cycle. lk_tx_valid and lk_tx_data stay unchanged until lk_tx_ready. Output status (offset 0x3) bit 0 is 1 exactly in TX_IDLE.
- R9: Writing offset 0x1 in TX_SEND is dropped: lk_tx_data is kept, and the sticky overrun bit (bit 2 of offset 0x3) is set.
- R10: A write to a status register loads its interrupt enable (bit 1) from data bit 1 and clears its sticky bit when data bit 2 is 1. A write of 0x00 therefore clears the enable and leaves the sticky bit alone. A status read returns {5'b0, sticky, enable, ready}.
- R11: irq is high exactly when (rx enable and RX_FULL) or (tx enable and TX_IDLE).
- R12: After reset, cpu_reset and cpu_analyse are 0, both enables and both sticky bits are 0, the receive direction is RX_EMPTY and the transmit direction is TX_IDLE. Offset 0x2 reads 0x00 and offset 0x3 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot | input | SLOT_W | Slot number used when SLOT_MODE=1 |
| host_addr | input | ADDR_W | Host address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| lk_rx_valid | input | 1 | Link core offers a received byte |
| lk_rx_data | input | 8 | Received byte |
| lk_rx_ready | output | 1 | Block can take a received byte |
| lk_tx_valid | output | 1 | Byte waiting to be sent |
| lk_tx_data | output | 8 | Byte to send |
| lk_tx_ready | input | 1 | Link core takes the byte |
| cpu_reset | output | 1 | Processor reset line |
| cpu_analyse | output | 1 | Processor analyse line |
| cpu_error | input | 1 | Processor error flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the host never raises host_rd and host_wr together and that each access lasts exactly one cycle. They also assume that the link core holds lk_rx_data steady while it offers a byte. The bench drives every access through a task that raises a single strobe for one cycle and lowers it before the next access. It offers receive bytes for one cycle only, through a separate task. lk_tx_ready is kept low while the bench checks that the transmit byte is held, and is raised for exactly one cycle to complete the drain.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int BYTE_W = 8;

    localparam logic [3:0] OFF_RXD = 4'h0;
    localparam logic [3:0] OFF_TXD = 4'h1;
    localparam logic [3:0] OFF_IST = 4'h2;
    localparam logic [3:0] OFF_OST = 4'h3;
    localparam logic [3:0] OFF_RST = 4'h8;
    localparam logic [3:0] OFF_ANA = 4'hC;

    typedef struct packed {
        logic rxd;
        logic txd;
        logic ist;
        logic ost;
        logic rst;
        logic ana;
    } win_sel_t;

    typedef enum logic {RX_EMPTY, RX_FULL} rx_state_t;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
endpackage

// File: rtl/hl_win_decode.sv
module hl_win_decode
    import hl_pkg::*;
#(
    parameter int           ADDR_W     = 16,
    parameter int           SLOT_W     = 3,
    parameter bit           SLOT_MODE  = 1'b0,
    parameter logic [15:0]  FIXED_BASE = 16'hDE00,
    parameter logic [15:0]  SLOT_BASE  = 16'hC080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] addr,
    output win_sel_t          sel
);
    localparam int HI_W = ADDR_W - 4;

    logic [HI_W-1:0] base_hi;
    logic [HI_W-1:0] slot_ext;
    logic            hit;
    logic [3:0]      off;

    assign slot_ext = {{(HI_W-SLOT_W){1'b0}}, slot};
    assign base_hi  = SLOT_MODE ? (SLOT_BASE[ADDR_W-1:4] + slot_ext)
                                : FIXED_BASE[ADDR_W-1:4];
    assign hit      = (addr[ADDR_W-1:4] == base_hi);
    assign off      = addr[3:0];

    always_comb begin
        sel     = '0;
        sel.rxd = hit && (off == OFF_RXD);
        sel.txd = hit && (off == OFF_TXD);
        sel.ist = hit && (off == OFF_IST);
        sel.ost = hit && (off == OFF_OST);
        sel.rst = hit && (off == OFF_RST);
        sel.ana = hit && (off == OFF_ANA);
    end

    // R2: at most one register is selected for any address
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/hl_rx_chan.sv
module hl_rx_chan
    import hl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [BYTE_W-1:0] lk_data,
    output logic              lk_ready,
    input  logic              pop,
    input  logic              stat_wr,
    input  logic              stat_ien,
    input  logic              stat_clr,
    output logic [BYTE_W-1:0] hold,
    output logic              full,
    output logic              ien,
    output logic              underrun
);
    rx_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_EMPTY: if (lk_valid) nxt = RX_FULL;
            RX_FULL:  if (pop)      nxt = RX_EMPTY;
        endcase
    end

    always_comb begin
        lk_ready = 1'b0;
        full     = 1'b0;
        unique case (state)
            RX_EMPTY: lk_ready = 1'b1;
            RX_FULL:  full     = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold     <= '0;
            ien      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (state == RX_EMPTY && lk_valid) hold <= lk_data;
            if (stat_wr) ien <= stat_ien;
            if (pop && state == RX_EMPTY)  underrun <= 1'b1;
            else if (stat_wr && stat_clr)  underrun <= 1'b0;
        end
    end

    a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_FULL) |=> $stable(hold));
    a_r6_consume_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state == RX_FULL) |=> lk_ready);
    a_r7_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state == RX_EMPTY) |=> underrun);
endmodule

// File: rtl/hl_tx_chan.sv
module hl_tx_chan
    import hl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    output logic              lk_valid,
    output logic [BYTE_W-1:0] lk_data,
    input  logic              lk_ready,
    input  logic              stat_wr,
    input  logic              stat_ien,
    input  logic              stat_clr,
    output logic              idle,
    output logic              ien,
    output logic              overrun
);
    tx_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (push)     nxt = TX_SEND;
            TX_SEND: if (lk_ready) nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        lk_valid = 1'b0;
        idle     = 1'b0;
        unique case (state)
            TX_IDLE: idle     = 1'b1;
            TX_SEND: lk_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_data <= '0;
            ien     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (state == TX_IDLE && push) lk_data <= push_data;
            if (stat_wr) ien <= stat_ien;
            if (push && state == TX_SEND) overrun <= 1'b1;
            else if (stat_wr && stat_clr) overrun <= 1'b0;
        end
    end

    a_r8_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> (lk_valid && $stable(lk_data)));
    a_r9_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state == TX_SEND) |=> (overrun && $stable(lk_data)));
endmodule

// File: rtl/hl_regif.sv
module hl_regif
    import hl_pkg::*;
#(
    parameter int           ADDR_W     = 16,
    parameter int           SLOT_W     = 3,
    parameter bit           SLOT_MODE  = 1'b0,
    parameter logic [15:0]  FIXED_BASE = 16'hDE00,
    parameter logic [15:0]  SLOT_BASE  = 16'hC080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              lk_rx_valid,
    input  logic [7:0]        lk_rx_data,
    output logic              lk_rx_ready,
    output logic              lk_tx_valid,
    output logic [7:0]        lk_tx_data,
    input  logic              lk_tx_ready,
    output logic              cpu_reset,
    output logic              cpu_analyse,
    input  logic              cpu_error,
    output logic              irq
);
    win_sel_t          sel;
    logic [BYTE_W-1:0] rx_hold;
    logic              rx_full, rx_ien, rx_under;
    logic              tx_idle, tx_ien, tx_over;

    hl_win_decode #(
        .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .SLOT_MODE(SLOT_MODE),
        .FIXED_BASE(FIXED_BASE), .SLOT_BASE(SLOT_BASE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .slot(slot), .addr(host_addr), .sel(sel)
    );

    hl_rx_chan u_rx (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_rx_valid), .lk_data(lk_rx_data), .lk_ready(lk_rx_ready),
        .pop(host_rd && sel.rxd),
        .stat_wr(host_wr && sel.ist),
        .stat_ien(host_wdata[1]), .stat_clr(host_wdata[2]),
        .hold(rx_hold), .full(rx_full), .ien(rx_ien), .underrun(rx_under)
    );

    hl_tx_chan u_tx (
        .clk(clk), .rst_n(rst_n),
        .push(host_wr && sel.txd), .push_data(host_wdata),
        .lk_valid(lk_tx_valid), .lk_data(lk_tx_data), .lk_ready(lk_tx_ready),
        .stat_wr(host_wr && sel.ost),
        .stat_ien(host_wdata[1]), .stat_clr(host_wdata[2]),
        .idle(tx_idle), .ien(tx_ien), .overrun(tx_over)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_reset   <= 1'b0;
            cpu_analyse <= 1'b0;
        end else if (host_wr) begin
            if (sel.rst) cpu_reset   <= host_wdata[0];
            if (sel.ana) cpu_analyse <= host_wdata[0];
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (1'b1)
                sel.rxd: host_rdata = rx_hold;
                sel.ist: host_rdata = {5'b0, rx_under, rx_ien, rx_full};
                sel.ost: host_rdata = {5'b0, tx_over, tx_ien, tx_idle};
                sel.rst: host_rdata = {7'b0, cpu_error};
                sel.ana: host_rdata = {7'b0, cpu_analyse};
                default: host_rdata = '0;
            endcase
        end
    end

    assign irq = (rx_ien && rx_full) || (tx_ien && tx_idle);

    a_r3_reset_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel.rst) |=> (cpu_reset == $past(host_wdata[0])));
    a_r4_analyse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel.ana) |=> (cpu_analyse == $past(host_wdata[0])));
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_ien || tx_ien));
    a_r2_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr));
endmodule

// File: tb/hl_regif_bench.sv
module hl_regif_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, rdata_s;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, rx_ready_s;
    logic       tx_valid, tx_valid_s;
    logic [7:0] tx_data, tx_data_s;
    logic       tx_ready = 1'b0;
    logic       creset, canalyse, creset_s, canalyse_s;
    logic       cerror = 1'b0;
    logic       irq, irq_s;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hl_regif u_hl_regif (
        .clk(clk), .rst_n(rst_n), .slot(3'd3), .host_addr(addr),
        .host_rd(rd), .host_wr(wr), .host_wdata(wdata), .host_rdata(rdata),
        .lk_rx_valid(rx_valid), .lk_rx_data(rx_data), .lk_rx_ready(rx_ready),
        .lk_tx_valid(tx_valid), .lk_tx_data(tx_data), .lk_tx_ready(tx_ready),
        .cpu_reset(creset), .cpu_analyse(canalyse), .cpu_error(cerror), .irq(irq)
    );

    hl_regif #(.SLOT_MODE(1'b1)) u_hl_regif_slot (
        .clk(clk), .rst_n(rst_n), .slot(3'd3), .host_addr(addr),
        .host_rd(rd), .host_wr(wr), .host_wdata(wdata), .host_rdata(rdata_s),
        .lk_rx_valid(1'b0), .lk_rx_data(8'h00), .lk_rx_ready(rx_ready_s),
        .lk_tx_valid(tx_valid_s), .lk_tx_data(tx_data_s), .lk_tx_ready(1'b0),
        .cpu_reset(creset_s), .cpu_analyse(canalyse_s), .cpu_error(1'b1), .irq(irq_s)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected byte for every host read
    always @(negedge clk) begin
        if (rd && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic host_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        addr = a; rd = 1'b1;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic link_offer(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 cpu_reset", {7'b0, creset}, 8'h00);
        check("R12 cpu_analyse", {7'b0, canalyse}, 8'h00);
        check("R12 irq", {7'b0, irq}, 8'h00);
        check("R12 tx_valid", {7'b0, tx_valid}, 8'h00);
        check("R12 rx_ready", {7'b0, rx_ready}, 8'h01);
        host_read(16'hDE02, 8'h00, "R12 in status");
        host_read(16'hDE03, 8'h01, "R12 out status");

        // R3 reset line and error readback
        host_write(16'hDE08, 8'hFF);
        @(negedge clk); check("R3 reset set", {7'b0, creset}, 8'h01);
        cerror = 1'b1;
        host_read(16'hDE08, 8'h01, "R3 error high");
        cerror = 1'b0;
        host_read(16'hDE08, 8'h00, "R3 error low");
        host_write(16'hDE08, 8'h00);
        @(negedge clk); check("R3 reset clear", {7'b0, creset}, 8'h00);

        // R4 analyse
        host_write(16'hDE0C, 8'h01);
        @(negedge clk); check("R4 analyse set", {7'b0, canalyse}, 8'h01);
        host_read(16'hDE0C, 8'h01, "R4 analyse readback");

        // R2 unused offsets
        host_write(16'hDE05, 8'hFF);
        host_read(16'hDE05, 8'h00, "R2 unused read");
        host_write(16'hDE0D, 8'h00);
        @(negedge clk); check("R2 unused write no analyse effect", {7'b0, canalyse}, 8'h01);
        @(negedge clk); check("R2 unused write no reset effect", {7'b0, creset}, 8'h00);

        // R1 outside the window
        host_write(16'hDF0C, 8'h00);
        @(negedge clk); check("R1 outside write ignored", {7'b0, canalyse}, 8'h01);
        host_read(16'hDD03, 8'h00, "R1 outside read");

        // R5 / R6 receive
        link_offer(8'h5A);
        @(negedge clk); check("R5 ready low when full", {7'b0, rx_ready}, 8'h00);
        host_read(16'hDE02, 8'h01, "R5 byte waiting");
        link_offer(8'h99);
        host_read(16'hDE00, 8'h5A, "R6 consume byte");
        @(negedge clk); check("R6 ready after consume", {7'b0, rx_ready}, 8'h01);
        host_read(16'hDE02, 8'h00, "R6 status empty");

        // R7 underrun
        host_read(16'hDE00, 8'h5A, "R7 last byte on empty read");
        host_read(16'hDE02, 8'h04, "R7 underrun sticky");
        // R10 clear sticky
        host_write(16'hDE02, 8'h04);
        host_read(16'hDE02, 8'h00, "R10 underrun cleared");

        // R8 / R9 transmit
        host_write(16'hDE01, 8'h33);
        @(negedge clk);
        check("R8 tx_valid", {7'b0, tx_valid}, 8'h01);
        check("R8 tx_data", tx_data, 8'h33);
        host_read(16'hDE03, 8'h00, "R8 busy status");
        host_write(16'hDE01, 8'h44);
        host_read(16'hDE03, 8'h04, "R9 overrun sticky");
        @(negedge clk); check("R9 tx_data kept", tx_data, 8'h33);
        @(posedge clk); #1 tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
        @(negedge clk); check("R8 drained", {7'b0, tx_valid}, 8'h00);
        host_read(16'hDE03, 8'h05, "R8 idle with overrun");

        // R11 / R10 interrupts
        host_write(16'hDE03, 8'h06);
        @(negedge clk); check("R11 irq tx idle enabled", {7'b0, irq}, 8'h01);
        host_read(16'hDE03, 8'h03, "R10 enable set and sticky cleared");
        host_write(16'hDE03, 8'h00);
        @(negedge clk); check("R10 zero clears enable", {7'b0, irq}, 8'h00);
        host_write(16'hDE02, 8'h02);
        @(negedge clk); check("R11 rx enabled but empty", {7'b0, irq}, 8'h00);
        link_offer(8'h77);
        @(negedge clk); check("R11 irq rx full", {7'b0, irq}, 8'h01);
        host_read(16'hDE00, 8'h77, "R6 second byte");
        @(negedge clk); check("R11 irq drops after consume", {7'b0, irq}, 8'h00);

        // R1 slot-relative base: 0xC080 + 16*3 = 0xC0B0
        host_read(16'hC0B3, 8'h00, "R1 fixed instance ignores slot window");
        @(posedge clk); #1 addr = 16'hC0B3; rd = 1'b1;
        @(negedge clk); check("R1 slot instance out status", rdata_s, 8'h01);
        @(posedge clk); #1 addr = 16'hC0B8;
        @(negedge clk); check("R1 slot instance error readback", rdata_s, 8'h01);
        @(posedge clk); #1 rd = 1'b0;
        host_write(16'hC0B8, 8'h01);
        @(negedge clk);
        check("R1 slot reset set", {7'b0, creset_s}, 8'h01);
        check("R1 fixed reset untouched", {7'b0, creset}, 8'h00);

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule